// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Filter Using Distributed Arithmetic

This block filters a stream of 16-bit two's-complement samples through a 32-tap linear-phase FIR whose impulse response is even-symmetric. It uses no multipliers. Each accepted sample is widened by one sign bit and enters a 32-deep history of 17-bit words. The words are then walked one bit at a time, least significant bit first. For each bit position, a serial adder sums every mirror pair of taps, which share one coefficient. The resulting 16 pre-added bits address four small tables of partial coefficient sums. The table outputs are summed, and a shift-accumulator weights each bit slice. The slice holding the sign bit is subtracted instead of added.

The coefficients are an elaboration-time parameter that holds the first half of the response. The tables are computed from that parameter. A sample is taken on an in_valid/in_ready handshake. The filter is busy for 17 bit cycles plus two overhead cycles. The result is then scaled by a fixed right shift, saturated to 16 bits, and held in a register that a one-cycle strobe marks.

Top module: `da_fir_filter`

## Requirements
- R1: After synchronous active-low reset, out_valid is 0, out_data is 0, in_ready is 1, and every history entry is zero.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle until the result strobe.
- R3: out_valid is a one-cycle pulse. It is registered at the 18th rising edge after the accepting edge. in_ready is 1 again in that same cycle.
- R4: Tap 0 is the newest accepted sample. For k = 0..15, coefficient h[k] = h[31−k] = COEFS[16k+15:16k] (signed). out_data = sat16((Σ h[k]·x[n−k]) >>> 15), where >>> is an arithmetic shift and sat16 clamps to [−32768, 32767].
- R5: A single sample affects exactly the 32 results that follow its acceptance and no later ones. An impulse therefore reproduces the scaled coefficient list forwards and then backwards.
- R6: Negative inputs, including −32768 in both taps of a pair, are handled exactly. The sign bit slice carries negative weight and no pre-add overflows.
- R7: A scaled sum above 32767 gives 32767, and one below −32768 gives −32768.
- R8: out_data does not change in any cycle where out_valid is 0.
- R9: in_valid asserted while in_ready is 0 has no effect. The sample offered is not entered into the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter idle, can take a sample |
| in_data | input | 16 | Two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe, new result on out_data |
| out_data | output | 16 | Saturated, scaled filter output |

## Verification
A positive full-scale impulse followed by zeros shows the tap order and the mirror pairing. It also shows that history drops out after 32 results. A negative full-scale impulse isolates the subtracted sign slice. A repeating five-sample sine-like sequence exercises mixed-sign pre-adds with carries running through every bit. Constant full-scale runs of both polarities drive the pre-adders to their extremes and the output into saturation. Samples offered while the filter is busy must leave the next results unchanged.

// File: rtl/da_fir_pkg.sv
// Shared types for the distributed-arithmetic FIR filter.
// Assumes nothing beyond SystemVerilog packages.
package da_fir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } da_state_e;
endpackage

// File: rtl/da_tap_line.sv
// Sample history as TAPS words of XW bits, exposed one bit slice at a time.
// load shifts a new word in at tap 0; rotate turns every word right by one
// bit so bit slice b appears on lsb_bits after b rotations. XW rotations
// restore alignment. Assumes load and rotate are never asserted together.
module da_tap_line #(
    parameter int TAPS = 32,
    parameter int XW   = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            rotate,
    input  logic [XW-1:0]   din,
    output logic [TAPS-1:0] lsb_bits
);
    logic [XW-1:0] tap [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        // Shift a word in, or rotate the word to present its next bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap[i] <= '0;
            end else if (load) begin
                if (i == 0) tap[i] <= din;
                else        tap[i] <= tap[(i == 0) ? 0 : i-1];
            end else if (rotate) begin
                tap[i] <= {tap[i][0], tap[i][XW-1:1]};
            end
        end
        assign lsb_bits[i] = tap[i][0];
    end

    a_r2_load_not_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && rotate));
endmodule

// File: rtl/da_preadd.sv
// Bit-serial adders that sum each mirror tap pair (k, TAPS-1-k).
// The sum bit is combinational from the current slice; carries are
// registered. Assumes operands are sign-extended so the sum fits.
module da_preadd #(
    parameter int TAPS  = 32,
    parameter int NPAIR = TAPS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [TAPS-1:0]  bits,
    output logic [NPAIR-1:0] sum_bits
);
    logic [NPAIR-1:0] carry;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        logic a, b;
        assign a = bits[k];
        assign b = bits[TAPS-1-k];
        assign sum_bits[k] = a ^ b ^ carry[k];

        // Carry of this pair's serial adder, cleared per sample.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) carry[k] <= 1'b0;
            else if (step)       carry[k] <= (a & b) | (a & carry[k]) | (b & carry[k]);
        end
    end

    a_r4_clear_not_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && step));
endmodule

// File: rtl/da_lut_bank.sv
// Partitioned lookup: NPAIR address bits split into groups of LUT_IN.
// Each group reads a 2^LUT_IN entry table of coefficient sums built at
// elaboration; the group results are sign-extended and added.
module da_lut_bank #(
    parameter int COEF_W = 16,
    parameter int NPAIR  = 16,
    parameter int LUT_IN = 4,
    parameter int TW     = COEF_W + $clog2(LUT_IN),
    parameter int SW     = TW + 2,
    parameter logic [NPAIR*COEF_W-1:0] COEFS = '0
) (
    input  logic [NPAIR-1:0]     addr,
    output logic signed [SW-1:0] tsum
);
    localparam int NLUT  = NPAIR / LUT_IN;
    localparam int DEPTH = 1 << LUT_IN;

    // Sum of the coefficients whose address bit is set in entry e of group g.
    function automatic logic signed [TW-1:0] entry_val(input int g, input int e);
        logic signed [TW-1:0]     s;
        logic signed [COEF_W-1:0] c;
        s = '0;
        for (int j = 0; j < LUT_IN; j++) begin
            if (e[j]) begin
                c = COEFS[(g*LUT_IN+j)*COEF_W +: COEF_W];
                s = s + TW'(c);
            end
        end
        return s;
    endfunction

    logic signed [TW-1:0] tbl [NLUT][DEPTH];

    for (genvar g = 0; g < NLUT; g++) begin : g_lut
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            localparam logic signed [TW-1:0] ENT = entry_val(g, e);
            assign tbl[g][e] = ENT;
        end
    end

    // Read each partial table and add the sign-extended results.
    always_comb begin
        tsum = '0;
        for (int g = 0; g < NLUT; g++) begin
            tsum = tsum + SW'(tbl[g][addr[g*LUT_IN +: LUT_IN]]);
        end
    end
endmodule

// File: rtl/da_shift_acc.sv
// Shift-accumulator: adds the slice sum aligned at weight 2^XW and shifts
// right by one each step; on the last (sign) slice it subtracts. After XW
// steps acc equals sum_b T_b*2^b minus T_sign*2^(XW-1), exactly.
module da_shift_acc #(
    parameter int SW = 20,
    parameter int XW = 17,
    parameter int AW = SW + XW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic                 last,
    input  logic signed [SW-1:0] tsum,
    output logic signed [AW-1:0] acc
);
    logic signed [AW-1:0] term, nxt;

    // Align the slice sum and add or subtract it.
    always_comb begin
        term = AW'(tsum) <<< XW;
        nxt  = last ? (acc - term) : (acc + term);
    end

    // Accumulator register with per-sample clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (step)       acc <= nxt >>> 1;
    end
endmodule

// File: rtl/da_fir_filter.sv
// Top of the symmetric distributed-arithmetic FIR filter.
// Accepts one sample per handshake, runs XW bit slices through the pre-adders,
// tables and accumulator, then scales, saturates and registers the result.
// Assumes TAPS is even and TAPS/2 is a multiple of LUT_IN.
module da_fir_filter
    import da_fir_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int TAPS      = 32,
    parameter int LUT_IN    = 4,
    parameter int OUT_SHIFT = 15,
    parameter logic [TAPS/2*COEF_W-1:0] COEFS = {
        16'(9800),  16'(5200),  16'(-1900), 16'(2100),
        16'(3400),  16'(1700),  16'(-300),  16'(-1250),
        16'(-880),  16'(-60),   16'(420),   16'(380),
        16'(90),    16'(-150),  16'(-210),  16'(-120)}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int XW    = DATA_W + 1;
    localparam int NPAIR = TAPS / 2;
    localparam int NLUT  = NPAIR / LUT_IN;
    localparam int TW    = COEF_W + $clog2(LUT_IN);
    localparam int SW    = TW + $clog2(NLUT);
    localparam int AW    = SW + XW + 2;
    localparam int CNT_W = $clog2(XW);
    localparam logic signed [AW-1:0] YMAX = (AW'(1) <<< (DATA_W-1)) - AW'(1);
    localparam logic signed [AW-1:0] YMIN = -(AW'(1) <<< (DATA_W-1));

    da_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic                 accept, run, last;
    logic [TAPS-1:0]      slice;
    logic [NPAIR-1:0]     paddr;
    logic signed [SW-1:0] tsum;
    logic signed [AW-1:0] acc, scaled;
    logic [DATA_W-1:0]    sat_val;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign run      = (state == ST_RUN);
    assign last     = run && (cnt == CNT_W'(XW-1));

    da_tap_line #(.TAPS(TAPS), .XW(XW)) u_taps (
        .clk(clk), .rst_n(rst_n), .load(accept), .rotate(run),
        .din({in_data[DATA_W-1], in_data}), .lsb_bits(slice));

    da_preadd #(.TAPS(TAPS), .NPAIR(NPAIR)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(run),
        .bits(slice), .sum_bits(paddr));

    da_lut_bank #(.COEF_W(COEF_W), .NPAIR(NPAIR), .LUT_IN(LUT_IN),
                  .TW(TW), .SW(SW), .COEFS(COEFS)) u_lut (
        .addr(paddr), .tsum(tsum));

    da_shift_acc #(.SW(SW), .XW(XW), .AW(AW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(run),
        .last(last), .tsum(tsum), .acc(acc));

    // Sequence one sample: idle, XW bit slices, then result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    cnt <= cnt + CNT_W'(1);
                    if (last) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Fixed scaling and clamp to the output width.
    always_comb begin
        scaled = acc >>> OUT_SHIFT;
        if (scaled > YMAX)      sat_val = YMAX[DATA_W-1:0];
        else if (scaled < YMIN) sat_val = YMIN[DATA_W-1:0];
        else                    sat_val = scaled[DATA_W-1:0];
    end

    // Output register and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state == ST_DONE);
            if (state == ST_DONE) out_data <= sat_val;
        end
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r3_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

// File: tb/tb_da_fir_filter.sv
// Scoreboard bench: the driver pushes model results, the monitor compares.
module tb_da_fir_filter;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int TAPS  = 32;
    localparam int NP    = TAPS / 2;
    localparam int SHIFT = 15;
    localparam int LAT   = 18;
    localparam logic [NP*16-1:0] TB_COEFS = {
        16'(9800),  16'(5200),  16'(-1900), 16'(2100),
        16'(3400),  16'(1700),  16'(-300),  16'(-1250),
        16'(-880),  16'(-60),   16'(420),   16'(380),
        16'(90),    16'(-150),  16'(-210),  16'(-120)};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_data = '0;
    logic out_valid;
    logic [DW-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_fir_filter #(.COEFS(TB_COEFS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

    typedef struct {
        logic [DW-1:0] val;
        int            cyc;
        string         req;
    } exp_t;

    exp_t          sbq[$];
    int            hist[TAPS];
    int            checks = 0;
    int            errors = 0;
    int            cycn = 0;
    bit            done = 1'b0;
    logic [DW-1:0] last_out = '0;

    always @(posedge clk) cycn <= cycn + 1;

    function automatic int coef(input int k);
        int idx;
        idx = (k < NP) ? k : TAPS - 1 - k;
        return int'($signed(TB_COEFS[idx*16 +: 16]));
    endfunction

    // Direct-form convolution, shift and clamp (R4, R7).
    function automatic logic [DW-1:0] model();
        longint s;
        s = 0;
        for (int k = 0; k < TAPS; k++) s += longint'(coef(k)) * longint'(hist[k]);
        s = s >>> SHIFT;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s[DW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: offer a sample, record its model result; optionally offer junk while busy (R9).
    task automatic send(input logic [DW-1:0] x, input string req, input int junk);
        exp_t e;
        do @(negedge clk); while (!in_ready);
        in_valid = 1'b1;
        in_data  = x;
        for (int i = TAPS-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'($signed(x));
        e.val = model();
        e.cyc = cycn + 1;
        e.req = req;
        sbq.push_back(e);
        @(negedge clk);
        check(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
        if (junk > 0) begin
            in_data = 16'h7FFF;
            repeat (junk) @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // Monitor: compare results, latency (R3) and output hold (R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R3 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(out_data == e.val, e.req, int'($signed(out_data)), int'($signed(e.val)));
                    check(cycn == e.cyc + LAT, "R3 latency", cycn - e.cyc, LAT);
                    check(in_ready == 1'b1, "R3 ready with result", int'(in_ready), 1);
                end
                last_out = out_data;
            end else begin
                check(out_data == last_out, "R8 hold", int'($signed(out_data)), int'($signed(last_out)));
            end
        end
    end

    initial begin
        logic [DW-1:0] seq [5];
        seq[0] = 16'h0000; seq[1] = 16'h1ACB; seq[2] = 16'h108D;
        seq[3] = 16'hEF73; seq[4] = 16'hE538;
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_data == '0, "R1 out_data", int'(out_data), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        // R1, R5: first impulse sees a zero history; response ends after 32 results.
        send(16'h7FFF, "R5 positive impulse", 0);
        for (int i = 0; i < 35; i++) send(16'h0000, "R5 impulse tail", 0);
        // R6: negative full-scale impulse.
        send(16'h8000, "R6 negative impulse", 0);
        for (int i = 0; i < 33; i++) send(16'h0000, "R6 impulse tail", 0);
        // R4: repeating five-sample sequence.
        for (int i = 0; i < 40; i++) send(seq[i % 5], "R4 sequence", 0);
        // R9: samples offered while busy must be ignored.
        for (int i = 0; i < 10; i++) send(seq[i % 5], "R9 busy offers ignored", 5);
        // R7, R6: constant full-scale runs saturate both ways.
        for (int i = 0; i < 40; i++) send(16'h7FFF, "R7 positive full scale", 0);
        for (int i = 0; i < 40; i++) send(16'h8000, "R7 negative full scale", 0);
        while (sbq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule